// File: doc/BRIEF.md
# Eight-Point Forward DCT Datapath Without Multipliers

This block turns a vector of eight signed samples into the eight coefficients of the orthonormal one-dimensional DCT-II. It contains no hardware multiplier and no lookup ROM. The samples first pass through a butterfly that forms four pairwise sums and four pairwise differences. Because of this split, the four even-index coefficients depend only on the sums and the four odd-index coefficients depend only on the differences. Each half is then a 4x4 constant product.

Every cosine constant is a fixed-point value with twelve fractional bits. For each bit weight and each output, a network of adders and subtractors adds the butterfly terms whose constant has that bit set, giving one partial sum per weight. A tree of 4:2 carry-save compressors adds the partial sums, each shifted by its weight. A single carry-propagate adder then produces the exact product sum. That sum is rounded to an integer, with ties away from zero.

One vector may enter on every clock cycle. Each result appears three cycles after its input, marked by a valid strobe. The datapath is a plain pipeline: its only control state is the valid flag that travels with each stage. A vector of coefficients is usually fed into a transpose buffer and then into a second pass, which together form a 2-D transform.

Top module: `dct8_fwd`

## Requirements
- R1: The even coefficients depend only on the sums x(i)+x(7-i) and the odd coefficients depend only on the differences x(i)-x(7-i). A mirror-symmetric input therefore gives exactly zero at the odd outputs, an antisymmetric input gives exactly zero at the even outputs, and an input whose eight samples are all equal gives zero at every output except index 0.
- R2: Each coefficient k is within 1 LSB of round(s_k * sum over n of x(n)*cos((2n+1)k*pi/16)). The scale s_k is 1/(2*sqrt(2)) for k = 0 and 1/2 otherwise. An all-zero input gives all-zero outputs.
- R3: The DC output uses the 1/(2*sqrt(2)) scale. Eight samples of 255 give exactly 721 at index 0 and 0 elsewhere.
- R4: The exact product sum is rounded to nearest, with ties away from zero. The constants are cos values halved and rounded to 12 fractional bits, so the DC constant is 1448/4096. Eight samples of 32 give 91 at index 0, and eight samples of -32 give -91.
- R5: out_valid rises exactly three clock cycles after in_valid is sampled high. Back-to-back vectors come out back-to-back and in order.
- R6: A synchronous active-high rst clears all valid flags. out_valid is low from the first edge with rst high. No vector that was in flight when reset was applied comes out afterwards.
- R7: A cycle with in_valid low produces a cycle with out_valid low three cycles later. Bubbles keep their positions in the output stream.
- R8: Samples are 9-bit two's complement, with sample n at in_vec[9n+8:9n]. Coefficients are 15-bit two's complement, with coefficient k at out_vec[15k+14:15k]. Eight samples of -256 give exactly -724 at index 0, and every output stays within +/-768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears valid flags |
| in_valid | input | 1 | Marks in_vec as a vector to transform |
| in_vec | input | 72 | Eight 9-bit signed samples, sample n at bits 9n+8..9n |
| out_valid | output | 1 | Marks out_vec as a result |
| out_vec | output | 120 | Eight 15-bit signed coefficients, coefficient k at bits 15k+14..15k |

## Verification
The bench goes after the extremes of the input range. Full-scale positive and negative flat vectors catch a partial sum that was given too few bits or a shifted operand that lost its sign extension. Both of these show up as wrapped or wildly wrong DC values. Vectors of +32 and -32 land exactly on a rounding tie at the DC output, so a plain floor-based rounding returns -90 instead of -91. Mirror-symmetric and antisymmetric vectors expose a butterfly that pairs the wrong samples, or a constant with the wrong sign, because leakage appears in the half that must read zero. Streams with bubbles and a reset applied while vectors are in flight show whether any valid flag is lost, duplicated or left uncleared.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int NPT  = 8;
    localparam int HALF = NPT / 2;

    // cos(m*pi/16)/2 scaled by 2^16, for m = 0..8
    function automatic int cos_half_q16(input int m);
        case (m)
            0:       return 32768;
            1:       return 32138;
            2:       return 30273;
            3:       return 27246;
            4:       return 23170;
            5:       return 18205;
            6:       return 12540;
            7:       return 6393;
            default: return 0;
        endcase
    endfunction

    // reduced angle index for output k, folded column n (0..HALF-1)
    function automatic int angle_idx(input int k, input int n);
        int m;
        if (k == 0) return 4;          // DC uses cos(pi/4)/2 = 1/(2*sqrt(2))
        m = ((2 * n + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        if (m > 8)  m = 16 - m;
        return m;
    endfunction

    function automatic int angle_neg(input int k, input int n);
        int m;
        if (k == 0) return 0;
        m = ((2 * n + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        return (m > 8) ? 1 : 0;
    endfunction

    // magnitude of the constant rounded to frac fractional bits (1..16)
    function automatic int coef_mag(input int k, input int n, input int frac);
        int q;
        q = cos_half_q16(angle_idx(k, n));
        if (frac >= 16) return q;
        return (q + (1 << (15 - frac))) >> (16 - frac);
    endfunction

endpackage

// File: rtl/dct8_butterfly.sv
module dct8_butterfly
    import dct8_pkg::*;
#(
    parameter int IW = 9,
    parameter int VW = IW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [NPT*IW-1:0]   in_vec,
    output logic                bf_valid,
    output logic [HALF*VW-1:0]  sum_vec,
    output logic [HALF*VW-1:0]  diff_vec
);

    logic [VW-1:0] sum_c  [HALF];
    logic [VW-1:0] diff_c [HALF];

    for (genvar i = 0; i < HALF; i++) begin : g_pair
        logic [IW-1:0] lo_s;
        logic [IW-1:0] hi_s;
        logic [VW-1:0] lo_x;
        logic [VW-1:0] hi_x;
        assign lo_s = in_vec[i*IW +: IW];
        assign hi_s = in_vec[(NPT-1-i)*IW +: IW];
        assign lo_x = {{(VW-IW){lo_s[IW-1]}}, lo_s};
        assign hi_x = {{(VW-IW){hi_s[IW-1]}}, hi_s};
        assign sum_c[i]  = lo_x + hi_x;
        assign diff_c[i] = lo_x - hi_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bf_valid <= 1'b0;
        end else begin
            bf_valid <= in_valid;
        end
        for (int i = 0; i < HALF; i++) begin
            sum_vec[i*VW +: VW]  <= sum_c[i];
            diff_vec[i*VW +: VW] <= diff_c[i];
        end
    end

endmodule

// File: rtl/dct8_partial_net.sv
module dct8_partial_net
    import dct8_pkg::*;
#(
    parameter int VW    = 10,
    parameter int CFRAC = 12,
    parameter int PW    = VW + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bf_valid,
    input  logic [HALF*VW-1:0]        sum_vec,
    input  logic [HALF*VW-1:0]        diff_vec,
    output logic                      ps_valid,
    output logic [NPT*CFRAC*PW-1:0]   psum_vec
);

    logic [PW-1:0] term   [NPT][CFRAC][HALF];
    logic [PW-1:0] psum_c [NPT][CFRAC];

    // one term per (output, bit weight, folded column): selected, negated or zero
    for (genvar k = 0; k < NPT; k++) begin : g_out
        for (genvar n = 0; n < HALF; n++) begin : g_col
            localparam int MAG = coef_mag(k, n, CFRAC);
            localparam bit NEG = (angle_neg(k, n) != 0);
            logic [VW-1:0] src;
            logic [PW-1:0] src_x;
            if (k % 2 == 0) begin : g_even
                assign src = sum_vec[n*VW +: VW];
            end else begin : g_odd
                assign src = diff_vec[n*VW +: VW];
            end
            assign src_x = {{(PW-VW){src[VW-1]}}, src};
            for (genvar b = 0; b < CFRAC; b++) begin : g_bit
                localparam bit ON = (((MAG >> b) & 1) == 1);
                if (!ON) begin : g_off
                    assign term[k][b][n] = '0;
                end else if (NEG) begin : g_sub
                    assign term[k][b][n] = '0 - src_x;
                end else begin : g_add
                    assign term[k][b][n] = src_x;
                end
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NPT; k++) begin
            for (int b = 0; b < CFRAC; b++) begin
                psum_c[k][b] = '0;
                for (int n = 0; n < HALF; n++) begin
                    psum_c[k][b] = psum_c[k][b] + term[k][b][n];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_valid <= 1'b0;
        end else begin
            ps_valid <= bf_valid;
        end
        for (int k = 0; k < NPT; k++) begin
            for (int b = 0; b < CFRAC; b++) begin
                psum_vec[(k*CFRAC+b)*PW +: PW] <= psum_c[k][b];
            end
        end
    end

endmodule

// File: rtl/dct8_csa42.sv
module dct8_csa42 #(
    parameter int W = 25
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);

    logic [W-1:0] s1;
    logic [W-1:0] c1;

    always_comb begin
        s1 = a ^ b ^ c;
        c1 = ((a & b) | (a & c) | (b & c)) << 1;
        s  = s1 ^ c1 ^ d;
        cy = ((s1 & c1) | (s1 & d) | (c1 & d)) << 1;
    end

endmodule

// File: rtl/dct8_ctree.sv
module dct8_ctree #(
    parameter int NIN = 12,
    parameter int W   = 25
) (
    input  logic [NIN*W-1:0] ops,
    output logic [W-1:0]     sum_a,
    output logic [W-1:0]     sum_b
);

    localparam int NPAD = (NIN <= 4) ? 4 : (1 << $clog2(NIN));
    localparam int LVLS = $clog2(NPAD) - 1;

    logic [W-1:0] lvl [LVLS+1][NPAD];

    for (genvar i = 0; i < NPAD; i++) begin : g_in
        if (i < NIN) begin : g_op
            assign lvl[0][i] = ops[i*W +: W];
        end else begin : g_pad
            assign lvl[0][i] = '0;
        end
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int NC = NPAD >> (l + 2);
        for (genvar c = 0; c < NC; c++) begin : g_cmp
            dct8_csa42 #(.W(W)) u_cmp (
                .a  (lvl[l][4*c]),
                .b  (lvl[l][4*c+1]),
                .c  (lvl[l][4*c+2]),
                .d  (lvl[l][4*c+3]),
                .s  (lvl[l+1][2*c]),
                .cy (lvl[l+1][2*c+1])
            );
        end
        for (genvar z = 2 * NC; z < NPAD; z++) begin : g_zero
            assign lvl[l+1][z] = '0;
        end
    end

    assign sum_a = lvl[LVLS][0];
    assign sum_b = lvl[LVLS][1];

endmodule

// File: rtl/dct8_weighted_sum.sv
module dct8_weighted_sum
    import dct8_pkg::*;
#(
    parameter int PW    = 12,
    parameter int CFRAC = 12,
    parameter int OW    = 15,
    parameter int AW    = PW + CFRAC + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ps_valid,
    input  logic [NPT*CFRAC*PW-1:0] psum_vec,
    output logic                    out_valid,
    output logic [NPT*OW-1:0]       out_vec
);

    localparam int QW = AW - CFRAC;
    localparam logic [AW-1:0] HALF_UP = AW'(1) << (CFRAC - 1);
    localparam logic [AW-1:0] HALF_DN = HALF_UP - AW'(1);

    logic [OW-1:0] coef_c [NPT];

    for (genvar k = 0; k < NPT; k++) begin : g_out
        logic [CFRAC*AW-1:0] ops;
        logic [AW-1:0]       sa;
        logic [AW-1:0]       sb;
        logic [AW-1:0]       total;
        logic [AW-1:0]       rounded;
        logic [QW-1:0]       q;

        for (genvar b = 0; b < CFRAC; b++) begin : g_wt
            logic [PW-1:0] p;
            assign p = psum_vec[(k*CFRAC+b)*PW +: PW];
            assign ops[b*AW +: AW] = {{(AW-PW){p[PW-1]}}, p} << b;
        end

        dct8_ctree #(.NIN(CFRAC), .W(AW)) u_tree (
            .ops   (ops),
            .sum_a (sa),
            .sum_b (sb)
        );

        always_comb begin
            total   = sa + sb;
            rounded = total + (total[AW-1] ? HALF_DN : HALF_UP);
            q       = rounded[AW-1:CFRAC];
            coef_c[k] = {{(OW-QW){q[QW-1]}}, q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= ps_valid;
        end
        for (int k = 0; k < NPT; k++) begin
            out_vec[k*OW +: OW] <= coef_c[k];
        end
    end

endmodule

// File: rtl/dct8_fwd.sv
module dct8_fwd
    import dct8_pkg::*;
#(
    parameter int IW    = 9,
    parameter int OW    = 15,
    parameter int CFRAC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [NPT*IW-1:0] in_vec,
    output logic              out_valid,
    output logic [NPT*OW-1:0] out_vec
);

    localparam int VW = IW + 1;
    localparam int PW = VW + 2;
    localparam int AW = PW + CFRAC + 1;

    logic                    bf_valid;
    logic [HALF*VW-1:0]      sum_vec;
    logic [HALF*VW-1:0]      diff_vec;
    logic                    ps_valid;
    logic [NPT*CFRAC*PW-1:0] psum_vec;

    dct8_butterfly #(.IW(IW), .VW(VW)) u_bfly (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vec   (in_vec),
        .bf_valid (bf_valid),
        .sum_vec  (sum_vec),
        .diff_vec (diff_vec)
    );

    dct8_partial_net #(.VW(VW), .CFRAC(CFRAC), .PW(PW)) u_pnet (
        .clk      (clk),
        .rst      (rst),
        .bf_valid (bf_valid),
        .sum_vec  (sum_vec),
        .diff_vec (diff_vec),
        .ps_valid (ps_valid),
        .psum_vec (psum_vec)
    );

    dct8_weighted_sum #(.PW(PW), .CFRAC(CFRAC), .OW(OW), .AW(AW)) u_wsum (
        .clk       (clk),
        .rst       (rst),
        .ps_valid  (ps_valid),
        .psum_vec  (psum_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

endmodule

// File: rtl/dct8_fwd_checker.sv
module dct8_fwd_checker
    import dct8_pkg::*;
#(
    parameter int IW = 9,
    parameter int OW = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [NPT*IW-1:0] in_vec,
    input logic              out_valid,
    input logic [NPT*OW-1:0] out_vec
);

    localparam int LIM = 3 * (1 << (IW - 1));

    logic [1:0] warm;
    logic       flat;
    logic       in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    always_comb begin
        flat = 1'b1;
        for (int n = 1; n < NPT; n++) begin
            if (in_vec[n*IW +: IW] != in_vec[IW-1:0]) flat = 1'b0;
        end
        in_range = 1'b1;
        for (int k = 0; k < NPT; k++) begin
            if (int'($signed(out_vec[k*OW +: OW])) > LIM ||
                int'($signed(out_vec[k*OW +: OW])) < -LIM) in_range = 1'b0;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R5

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd3) |-> !out_valid); // R6

    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(in_vec, 3) == '0) |-> (out_vec == '0)); // R2

    AST_FLAT_DC_ONLY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(flat, 3)) |-> (out_vec[NPT*OW-1:OW] == '0)); // R1

    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_range); // R8

endmodule

bind dct8_fwd dct8_fwd_checker #(.IW(IW), .OW(OW)) u_dct8_fwd_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/dct8_fwd_bench.sv
`timescale 1ns/1ps
module dct8_fwd_bench;

    localparam int  IW  = 9;
    localparam int  OW  = 15;
    localparam int  NPT = 8;
    localparam real PI  = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [NPT*IW-1:0] in_vec = '0;
    wire               out_valid;
    wire  [NPT*OW-1:0] out_vec;

    dct8_fwd #(.IW(IW), .OW(OW)) u_dct8_fwd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [NPT*IW-1:0] stim   [32];
    logic              stim_v [32];
    logic [NPT*OW-1:0] cap    [32];
    int                nstim;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NPT*IW-1:0] mk8(input int x [NPT]);
        logic [NPT*IW-1:0] v;
        for (int n = 0; n < NPT; n++) v[n*IW +: IW] = IW'(x[n]);
        return v;
    endfunction

    function automatic int sample(input logic [NPT*IW-1:0] v, input int n);
        return int'($signed(v[n*IW +: IW]));
    endfunction

    function automatic int coef(input logic [NPT*OW-1:0] v, input int k);
        return int'($signed(v[k*OW +: OW]));
    endfunction

    function automatic int ideal(input logic [NPT*IW-1:0] v, input int k);
        real acc = 0.0;
        for (int n = 0; n < NPT; n++)
            acc += real'(sample(v, n)) * $cos(real'((2 * n + 1) * k) * PI / 16.0);
        acc = acc * ((k == 0) ? (1.0 / (2.0 * $sqrt(2.0))) : 0.5);
        return (acc >= 0.0) ? int'($floor(acc + 0.5)) : -int'($floor(-acc + 0.5));
    endfunction

    // drive stim[0..nstim-1] on successive cycles, check each slot three cycles later
    task automatic run_stream(input string req);
        for (int c = 0; c < nstim + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                chk(out_valid == stim_v[c-3], "R5", int'(out_valid), int'(stim_v[c-3]),
                    $sformatf("%s out_valid slot %0d", req, c - 3));
                if (stim_v[c-3]) begin
                    cap[c-3] = out_vec;
                    for (int k = 0; k < NPT; k++) begin
                        int a = coef(out_vec, k);
                        int e = ideal(stim[c-3], k);
                        chk(a - e <= 1 && e - a <= 1, req == "" ? "R2" : req, a, e,
                            $sformatf("R2 coefficient %0d of slot %0d", k, c - 3));
                    end
                end
            end
            if (c < nstim) begin
                in_vec   = stim[c];
                in_valid = stim_v[c];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic one_vec(input logic [NPT*IW-1:0] v, input string req);
        stim[0] = v; stim_v[0] = 1'b1; nstim = 1;
        run_stream(req);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", int'(out_valid), 0, "out_valid during reset");
        end
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", int'(out_valid), 0, "out_valid after reset, no input");
        end
    endtask

    task automatic t_zero();
        one_vec('0, "R2");
        chk(cap[0] == '0, "R2", coef(cap[0], 0), 0, "all-zero vector");
    endtask

    task automatic t_full_scale();
        one_vec(mk8('{255, 255, 255, 255, 255, 255, 255, 255}), "R3");
        chk(coef(cap[0], 0) == 721, "R3", coef(cap[0], 0), 721, "DC of all 255");
        chk(cap[0][NPT*OW-1:OW] == '0, "R3", coef(cap[0], 1), 0, "AC of all 255");
        one_vec(mk8('{-256, -256, -256, -256, -256, -256, -256, -256}), "R8");
        chk(coef(cap[0], 0) == -724, "R8", coef(cap[0], 0), -724, "DC of all -256");
        chk(cap[0][NPT*OW-1:OW] == '0, "R8", coef(cap[0], 4), 0, "AC of all -256");
    endtask

    task automatic t_alternating();
        one_vec(mk8('{255, -256, 255, -256, 255, -256, 255, -256}), "R2");
        one_vec(mk8('{-256, 255, -256, 255, -256, 255, -256, 255}), "R8");
    endtask

    task automatic t_ties();
        one_vec(mk8('{32, 32, 32, 32, 32, 32, 32, 32}), "R4");
        chk(coef(cap[0], 0) == 91, "R4", coef(cap[0], 0), 91, "positive tie rounds up");
        one_vec(mk8('{-32, -32, -32, -32, -32, -32, -32, -32}), "R4");
        chk(coef(cap[0], 0) == -91, "R4", coef(cap[0], 0), -91, "negative tie rounds away from zero");
    endtask

    task automatic t_symmetry();
        one_vec(mk8('{10, -20, 30, -40, -40, 30, -20, 10}), "R1");
        for (int k = 1; k < NPT; k += 2)
            chk(coef(cap[0], k) == 0, "R1", coef(cap[0], k), 0, $sformatf("odd coef %0d of mirror input", k));
        one_vec(mk8('{50, -70, 90, -11, 11, -90, 70, -50}), "R1");
        for (int k = 0; k < NPT; k += 2)
            chk(coef(cap[0], k) == 0, "R1", coef(cap[0], k), 0, $sformatf("even coef %0d of antisymmetric input", k));
        one_vec(mk8('{-77, -77, -77, -77, -77, -77, -77, -77}), "R1");
        chk(cap[0][NPT*OW-1:OW] == '0, "R1", coef(cap[0], 2), 0, "AC of flat input");
    endtask

    task automatic t_random_stream();
        nstim = 24;
        for (int i = 0; i < nstim; i++) begin
            int x [NPT];
            for (int n = 0; n < NPT; n++) x[n] = int'($urandom_range(511)) - 256;
            stim[i] = mk8(x); stim_v[i] = 1'b1;
        end
        run_stream("R5");
    endtask

    task automatic t_bubbles();
        nstim = 8;
        for (int i = 0; i < nstim; i++) begin
            int x [NPT];
            for (int n = 0; n < NPT; n++) x[n] = int'($urandom_range(511)) - 256;
            stim[i] = mk8(x);
            stim_v[i] = (i % 3 != 1);
        end
        run_stream("R7");
    endtask

    task automatic t_reset_in_flight();
        @(negedge clk);
        in_vec = mk8('{1, 2, 3, 4, 5, 6, 7, 8}); in_valid = 1'b1;
        @(negedge clk);
        in_vec = mk8('{9, 9, 9, 9, 9, 9, 9, 9});
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", int'(out_valid), 0, "in-flight vector during reset");
        end
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", int'(out_valid), 0, "in-flight vector after reset");
        end
    endtask

    initial begin
        void'($urandom(11));
        t_reset_state();
        t_zero();
        t_full_scale();
        t_alternating();
        t_ties();
        t_symmetry();
        t_random_stream();
        t_bubbles();
        t_reset_in_flight();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule